// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the command layer of a slave-side serial EEPROM of 512 bytes. A bit-level SPI front end, outside this block, shifts the serial lines and hands over whole received bytes. It also loads the bytes this block offers for transmission and reports whether the chip-select session is open. The engine reads an 8-bit opcode and then runs one of six sequences: array read, array write, set or clear the write-enable latch, read the status byte, or write the status byte. Every other opcode is ignored.

Array writes collect up to a page of 16 bytes in a page buffer. The self-timed programming cycle starts only when the session closes. A programmable cycle counter stands in for the nonvolatile write time, and the array is a register memory. A separate protection unit looks at the current address and the block-protect level and returns two inhibit inputs: one for array writes and one for status writes. The engine only obeys them.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: After reset the status byte reads 0xF0, `busy` is low and `so_enable` is low.
- R2: The status byte is {4'b1111, block-protect[1:0], write-enable latch, busy}, with busy in bit 0. A status read repeats that byte live for as long as bytes are taken.
- R3: Write-enable (0x06) sets the latch and write-disable (0x04) clears it. Each takes effect only when the session closes right after the opcode byte. If any further byte arrives in that session, the latch is left unchanged.
- R4: Read is 0000_A011 and write is 0000_A010, where A (opcode bit 3) is address bit 8. One address byte follows, MSB first. A read returns bytes from consecutive addresses, and after 0x1FF it continues at 0x000.
- R5: Each complete data byte of a write goes to the current address. Only the low 4 address bits then advance, so loading wraps inside the 16-byte page and later bytes overwrite earlier ones.
- R6: A programming cycle starts when the session closes only if three things hold: the latch was set when the write opcode arrived, at least one complete data byte was received, and `arr_wr_inhibit` is low for the address on `prot_addr`. `busy` then stays high for exactly PROG_CYCLES clocks.
- R7: While `busy` is high, every opcode except status-read (0x05) is ignored. SO is not driven for such a command, and latch and memory are untouched.
- R8: The write-enable latch clears when an array or status programming cycle completes.
- R9: Write-status (0x01) needs the latch set. Only data bits 3:2 are kept, as the block-protect level on `bp_level`. The cycle is skipped when `sr_wr_inhibit` is high.
- R10: Any opcode not listed here is ignored: `so_enable` stays low and the status byte is unchanged.
- R11: `so_enable` is high only while a read or status-read session is streaming data. Each `tx_take` pulse during a read advances the address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | High while chip select is asserted (session open) |
| rx_valid | input | 1 | One-cycle strobe: a complete byte was received |
| rx_byte | input | 8 | Received byte, valid with rx_valid |
| tx_take | input | 1 | One-cycle strobe: front end loaded tx_byte into its shifter |
| tx_byte | output | 8 | Byte offered for transmission |
| so_enable | output | 1 | Front end should drive SO (otherwise high impedance) |
| arr_wr_inhibit | input | 1 | Protection unit forbids array writes at prot_addr |
| sr_wr_inhibit | input | 1 | Protection unit forbids status writes |
| prot_addr | output | 9 | Current address pointer, for the protection unit |
| bp_level | output | 2 | Block-protect level held in the status byte |
| busy | output | 1 | Internal programming cycle in progress |

## Verification
The assertions assume that the front end behaves as a real one would. Every byte strobe is a single cycle and arrives only while `cs_active` is high. `tx_take` is pulsed only while `so_enable` is high. The inhibit inputs are stable at the cycle in which the session closes. The bench drives every strobe for one cycle, with idle cycles between strobes. It changes the inhibit inputs only while no session is open, and it requests transmit bytes only inside read and status-read sessions.

// File: rtl/eep_cmd_pkg.sv
package eep_cmd_pkg;
  typedef enum logic [3:0] {
    ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_SRRD,
    ST_SRWR, ST_SRHOLD, ST_ARM, ST_SKIP
  } eep_state_e;

  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;

  function automatic logic op_is_read(input logic [7:0] b);
    return (b[7:4] == 4'h0) && (b[2:0] == 3'b011);
  endfunction

  function automatic logic op_is_write(input logic [7:0] b);
    return (b[7:4] == 4'h0) && (b[2:0] == 3'b010);
  endfunction
endpackage

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start && cnt_q == '0) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CYCLES));
  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int unsigned PAGE_BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [$clog2(PAGE_BYTES)-1:0] idx,
  input  logic [7:0]                din,
  output logic [PAGE_BYTES*8-1:0]   data_flat,
  output logic [PAGE_BYTES-1:0]     mask
);
  logic [PAGE_BYTES-1:0] mask_d;

  always_comb begin
    mask_d = mask;
    if (clr)     mask_d = '0;
    else if (wr) mask_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask <= '0;
    else if (clr || wr)  mask <= mask_d;
  end

  for (genvar l = 0; l < PAGE_BYTES; l++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (wr && idx == l) byte_q <= din;
    end
    assign data_flat[l*8 +: 8] = byte_q;
  end

  p_mask_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> mask[$past(idx)]);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
  input  logic [PAGE_BYTES*8-1:0]      data_flat,
  input  logic [PAGE_BYTES-1:0]        mask,
  input  logic [ADDR_W-1:0]            raddr,
  output logic [7:0]                   rdata
);
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < PAGE_BYTES; l++) begin
        if (mask[l]) mem[{page, OFF_W'(l)}] <= data_flat[l*8 +: 8];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
  import eep_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned PAGE_BYTES  = 16,
  parameter int unsigned PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_take,
  output logic [7:0]        tx_byte,
  output logic              so_enable,
  input  logic              arr_wr_inhibit,
  input  logic              sr_wr_inhibit,
  output logic [ADDR_W-1:0] prot_addr,
  output logic [1:0]        bp_level,
  output logic              busy
);
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  eep_state_e        st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              is_wr_q, is_wr_d;
  logic              a8_q, a8_d;
  logic              arm_q, arm_d;
  logic              wel_q, wel_d;
  logic [1:0]        bp_q, bp_d;
  logic [1:0]        srnew_q, srnew_d;
  logic              have_q, have_d;
  logic              kind_q, kind_d;
  logic              buf_clr, buf_wr, prog_start, prog_done;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0]   buf_mask;
  logic [7:0]        rd_data, status_byte;

  assign status_byte = {4'hF, bp_q, wel_q, busy};

  always_comb begin
    st_d = st_q; ptr_d = ptr_q; is_wr_d = is_wr_q; a8_d = a8_q;
    arm_d = arm_q; wel_d = wel_q; bp_d = bp_q; srnew_d = srnew_q;
    have_d = have_q; kind_d = kind_q;
    buf_clr = 1'b0; buf_wr = 1'b0; prog_start = 1'b0;
    if (!cs_active) begin
      st_d = ST_OPC;
      case (st_q)
        ST_ARM:    wel_d = arm_q;
        ST_WDATA:  if (have_q && wel_q && !arr_wr_inhibit) begin
                     prog_start = 1'b1; kind_d = 1'b0;
                   end
        ST_SRHOLD: if (wel_q && !sr_wr_inhibit) begin
                     prog_start = 1'b1; kind_d = 1'b1;
                   end
        default: ;
      endcase
    end else if (rx_valid) begin
      case (st_q)
        ST_OPC: begin
          if (busy && rx_byte != OP_STAT_RD)  st_d = ST_SKIP;
          else if (rx_byte == OP_STAT_RD)     st_d = ST_SRRD;
          else if (rx_byte == OP_SET_WEL)     begin st_d = ST_ARM; arm_d = 1'b1; end
          else if (rx_byte == OP_CLR_WEL)     begin st_d = ST_ARM; arm_d = 1'b0; end
          else if (rx_byte == OP_STAT_WR)     st_d = wel_q ? ST_SRWR : ST_SKIP;
          else if (op_is_read(rx_byte))       begin
            st_d = ST_ADDR; is_wr_d = 1'b0; a8_d = rx_byte[3];
          end else if (op_is_write(rx_byte))  begin
            st_d = wel_q ? ST_ADDR : ST_SKIP; is_wr_d = 1'b1; a8_d = rx_byte[3];
          end else                            st_d = ST_SKIP;
        end
        ST_ADDR: begin
          ptr_d   = ADDR_W'({a8_q, rx_byte});
          st_d    = is_wr_q ? ST_WDATA : ST_RDATA;
          buf_clr = is_wr_q;
          have_d  = 1'b0;
        end
        ST_WDATA: begin
          buf_wr = 1'b1;
          have_d = 1'b1;
          ptr_d  = {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + 1'b1};
        end
        ST_SRWR: begin
          srnew_d = rx_byte[3:2];
          st_d    = ST_SRHOLD;
        end
        ST_ARM:  st_d = ST_SKIP;
        default: ;
      endcase
    end else if (tx_take && st_q == ST_RDATA) begin
      ptr_d = ptr_q + 1'b1;
    end
    if (prog_done) begin
      wel_d = 1'b0;
      if (kind_q) bp_d = srnew_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OPC; ptr_q <= '0; is_wr_q <= 1'b0; a8_q <= 1'b0;
      arm_q <= 1'b0; wel_q <= 1'b0; bp_q <= 2'b00; srnew_q <= 2'b00;
      have_q <= 1'b0; kind_q <= 1'b0;
    end else begin
      st_q <= st_d; ptr_q <= ptr_d; is_wr_q <= is_wr_d; a8_q <= a8_d;
      arm_q <= arm_d; wel_q <= wel_d; bp_q <= bp_d; srnew_q <= srnew_d;
      have_q <= have_d; kind_q <= kind_d;
    end
  end

  eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_ni), .start(prog_start), .busy(busy), .done(prog_done)
  );

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_ni), .clr(buf_clr), .wr(buf_wr),
    .idx(ptr_q[OFF_W-1:0]), .din(rx_byte), .data_flat(buf_data), .mask(buf_mask)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_mem (
    .clk(clk), .we(prog_done && !kind_q), .page(ptr_q[ADDR_W-1:OFF_W]),
    .data_flat(buf_data), .mask(buf_mask), .raddr(ptr_q), .rdata(rd_data)
  );

  assign tx_byte   = (st_q == ST_SRRD) ? status_byte : rd_data;
  assign so_enable = cs_active && (st_q == ST_RDATA || st_q == ST_SRRD);
  assign prot_addr = ptr_q;
  assign bp_level  = bp_q;

  p_so_in_session_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    so_enable |-> cs_active);
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_OPC && cs_active && rx_valid && busy && rx_byte != OP_STAT_RD)
      |=> st_q == ST_SKIP);
  p_wel_clears_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    prog_done |=> !wel_q);
  p_start_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    prog_start |-> wel_q);
  p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_WDATA && cs_active && rx_valid)
      |=> ptr_q[ADDR_W-1:OFF_W] == $past(ptr_q[ADDR_W-1:OFF_W]));
  p_bp_only_on_sr_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (bp_q != $past(bp_q)) |-> $past(prog_done && kind_q));
endmodule

// File: tb/eeprom_cmd_engine_bench.sv
module eeprom_cmd_engine_bench;
  localparam int PROG = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_active = 1'b0, rx_valid = 1'b0, tx_take = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic arr_wr_inhibit = 1'b0, sr_wr_inhibit = 1'b0;
  logic [7:0] tx_byte;
  logic so_enable, busy;
  logic [8:0] prot_addr;
  logic [1:0] bp_level;

  int checks = 0, failures = 0;
  logic [7:0] model [512];

  typedef struct { logic [7:0] exp; string req; } sb_item_t;
  sb_item_t sbq [$];

  always #2.5 clk = ~clk;

  eeprom_cmd_engine #(.PROG_CYCLES(PROG)) u_eeprom_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_take(tx_take), .tx_byte(tx_byte),
    .so_enable(so_enable), .arr_wr_inhibit(arr_wr_inhibit),
    .sr_wr_inhibit(sr_wr_inhibit), .prot_addr(prot_addr),
    .bp_level(bp_level), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each transmitted byte against the scoreboard
  always @(negedge clk) begin
    #1;
    if (tx_take) begin
      sb_item_t it;
      if (sbq.size() == 0) chk("scoreboard-empty", 1, 0);
      else begin
        it = sbq.pop_front();
        chk(it.req, {23'd0, so_enable, tx_byte}, {23'd0, 1'b1, it.exp});
      end
    end
  end

  task automatic open_s();  @(negedge clk); cs_active = 1'b1; endtask
  task automatic close_s(); @(negedge clk); cs_active = 1'b0; endtask
  task automatic settle();  repeat (2) @(negedge clk); endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic take(input logic [7:0] e, input string req);
    sb_item_t it;
    it.exp = e; it.req = req;
    @(negedge clk); sbq.push_back(it); tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  task automatic cmd1(input logic [7:0] op);
    open_s(); send(op); close_s(); settle();
  endtask

  task automatic stat(input logic [7:0] e, input string req);
    open_s(); send(8'h05); take(e, req); close_s(); settle();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int blen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 so_enable", so_enable, 0);
    chk("R1 busy", busy, 0);
    open_s(); send(8'h05);
    take(8'hF0, "R1 status");
    take(8'hF0, "R2 status repeats");
    close_s(); settle();

    // R3 latch set / clear
    cmd1(8'h06); stat(8'hF2, "R3 wel set");
    cmd1(8'h04); stat(8'hF0, "R3 wel cleared");
    open_s(); send(8'h06); send(8'h00); close_s(); settle();
    stat(8'hF0, "R3 extra byte cancels set");

    // R6 write without latch
    open_s(); send(8'h02); send(8'h00); send(8'h99); close_s(); settle();
    chk("R6 no latch no cycle", busy, 0);

    // R6 full page write at 0x000, busy length
    cmd1(8'h06);
    open_s(); send(8'h02); send(8'h00);
    for (int i = 0; i < 16; i++) begin
      send(8'h10 + 8'(i)); model[i] = 8'h10 + 8'(i);
    end
    close_s();
    blen = 0;
    @(negedge clk);
    while (busy) begin blen++; @(negedge clk); end
    chk("R6 busy length", blen, PROG);
    settle();
    stat(8'hF0, "R8 wel cleared after array write");

    // R5 page wrap at top page, R7 during busy
    cmd1(8'h06);
    open_s(); send(8'h0A); send(8'hFC);
    for (int i = 0; i < 18; i++) begin
      send(8'hA0 + 8'(i));
      model[9'h1F0 | 9'((12 + i) % 16)] = 8'hA0 + 8'(i);
    end
    close_s(); settle();
    stat(8'hF3, "R7 status served while busy");
    open_s(); send(8'h03); send(8'h00); @(negedge clk);
    chk("R7 read ignored while busy", so_enable, 0);
    close_s(); settle();
    cmd1(8'h04);
    stat(8'hF3, "R7 clear-latch ignored while busy");
    wait_idle();
    stat(8'hF0, "R8 wel cleared after page write");

    // R4 read with A8 and array wrap, R11 streaming
    open_s(); send(8'h0B); send(8'hFA);
    for (int i = 0; i < 10; i++) take(model[9'(9'h1FA + 9'(i))], "R4 read stream");
    chk("R11 so_enable in read", so_enable, 1);
    close_s(); settle();
    chk("R11 so_enable after close", so_enable, 0);
    open_s(); send(8'h03); send(8'h0E);
    take(model[14], "R4 read low half"); take(model[15], "R11 pointer step");
    close_s(); settle();

    // R6 zero data bytes
    cmd1(8'h06);
    open_s(); send(8'h02); send(8'h40); close_s(); settle();
    chk("R6 zero bytes no cycle", busy, 0);
    stat(8'hF2, "R6 latch kept without cycle");

    // R6 protection inhibit
    arr_wr_inhibit = 1'b1;
    open_s(); send(8'h02); send(8'h05);
    chk("R6 prot_addr", prot_addr, 9'h005);
    send(8'h55); close_s(); settle();
    chk("R6 inhibited no cycle", busy, 0);
    arr_wr_inhibit = 1'b0;
    open_s(); send(8'h03); send(8'h05); take(model[5], "R6 inhibited data kept");
    close_s(); settle();
    cmd1(8'h04);

    // R10 unknown opcode
    open_s(); send(8'h07); @(negedge clk);
    chk("R10 unknown so_enable", so_enable, 0);
    close_s(); settle();
    open_s(); send(8'hFF); send(8'h05); @(negedge clk);
    chk("R10 unknown then bytes", so_enable, 0);
    close_s(); settle();
    stat(8'hF0, "R10 status unchanged");

    // R9 status write
    open_s(); send(8'h01); send(8'hFF); close_s(); settle();
    chk("R9 no latch no status cycle", busy, 0);
    cmd1(8'h06);
    open_s(); send(8'h01); send(8'hFF); close_s(); settle();
    chk("R9 status cycle started", busy, 1);
    wait_idle();
    stat(8'hFC, "R9 only bp bits kept");
    chk("R9 bp_level", bp_level, 2'b11);
    cmd1(8'h06);
    sr_wr_inhibit = 1'b1;
    open_s(); send(8'h01); send(8'h00); close_s(); settle();
    chk("R9 inhibited status write", busy, 0);
    sr_wr_inhibit = 1'b0;
    stat(8'hFE, "R9 bp unchanged when inhibited");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", sbq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule